// File: doc/BRIEF.md
# Integer Add, Subtract and Compare Unit

This unit is the arithmetic slice of a 64-bit integer execute stage. It takes two operands and a 7-bit function code and, with no register on the path, returns a 64-bit result, an overflow-trap flag and an illegal-operation flag. Whether the B operand comes from a register or a zero-extended literal is settled upstream. The unit only sees the value.

Three operand widths and forms are handled. Longword forms work on the low 32 bits and always sign-extend their 32-bit result. Quadword forms work on all 64 bits. Scaled forms shift A left by two or three places before adding or subtracting B. Two compare families are also provided. The scalar compares return 0 or 1. The byte-lane compare tests the eight bytes in parallel as unsigned values and returns an 8-bit mask. An overflow is reported only for the four trapping encodings. When it is reported, the result is still driven, so that the trap logic can decide whether to write it back.

Top module: `intArithUnit`

## Requirements
- R1: Codes 0x00 (add) and 0x09 (subtract) compute the low 32 bits of A plus or minus the low 32 bits of B. The 32-bit result is sign-extended from bit 31 into result[63:32].
- R2: Codes 0x20 (add) and 0x29 (subtract) compute the full 64-bit A plus or minus B, modulo 2^64.
- R3: Scaled codes shift A left by 2 (codes 0x02 and 0x0b long, 0x22 and 0x2b quad) or by 3 (codes 0x12 and 0x1b long, 0x32 and 0x3b quad) before adding (0x02, 0x12, 0x22, 0x32) or subtracting (0x0b, 0x1b, 0x2b, 0x3b) B. Long forms sign-extend from bit 31. No scaled code ever raises overflow.
- R4: Trapping add codes 0x40 (long) and 0x60 (quad) return the same result as 0x00 and 0x20. They raise overflow when A and B have equal sign bits and the result sign bit differs from A's. The sign bit is bit 31 for long and bit 63 for quad.
- R5: Trapping subtract codes 0x49 (long) and 0x69 (quad) return the same result as 0x09 and 0x29. They raise overflow when the sign bits of A and B differ and the result sign bit differs from A's. The sign bit is chosen as in R4.
- R6: The overflow output is 0 for every code other than 0x40, 0x60, 0x49 and 0x69, including operand pairs that would overflow under a trapping code.
- R7: Compare codes return 1 or 0 in the 64-bit result. The codes are 0x2d (A equals B), 0x6d (signed A ≤ B), 0x4d (signed A < B), 0x3d (unsigned A ≤ B) and 0x1d (unsigned A < B).
- R8: Code 0x0f sets result bit i (i = 0..7) when byte i of A, taken as unsigned bits [8i+7:8i], is greater than or equal to byte i of B. Result bits 63:8 are 0.
- R9: Any code not listed in R1 to R8 raises illegalOp, with result 0 and overflow 0. Every listed code drives illegalOp to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 64 | First operand; the one that is scaled |
| opB | input | 64 | Second operand, register or zero-extended literal |
| funcCode | input | 7 | Operation select |
| result | output | 64 | Arithmetic, compare or lane-mask result |
| overflow | output | 1 | Signed overflow on a trapping encoding |
| illegalOp | output | 1 | Function code not recognised |

## Verification
No register lies between the inputs and any output, so result, overflow and illegalOp all settle in the same cycle as the operands and function code that produce them. The bench changes inputs on the falling clock edge. It samples all three outputs one nanosecond later, well before the next rising edge. No output is ever compared against a value from an earlier cycle.

// File: rtl/intArithPkg.sv
package intArithPkg;

  localparam int FUNC_W = 7;

  // Function codes; values are fixed by the instruction encoding.
  localparam logic [FUNC_W-1:0] FN_ADDL   = 7'h00;
  localparam logic [FUNC_W-1:0] FN_ADDLV  = 7'h40;
  localparam logic [FUNC_W-1:0] FN_S4ADDL = 7'h02;
  localparam logic [FUNC_W-1:0] FN_S8ADDL = 7'h12;
  localparam logic [FUNC_W-1:0] FN_ADDQ   = 7'h20;
  localparam logic [FUNC_W-1:0] FN_ADDQV  = 7'h60;
  localparam logic [FUNC_W-1:0] FN_S4ADDQ = 7'h22;
  localparam logic [FUNC_W-1:0] FN_S8ADDQ = 7'h32;
  localparam logic [FUNC_W-1:0] FN_SUBL   = 7'h09;
  localparam logic [FUNC_W-1:0] FN_SUBLV  = 7'h49;
  localparam logic [FUNC_W-1:0] FN_S4SUBL = 7'h0b;
  localparam logic [FUNC_W-1:0] FN_S8SUBL = 7'h1b;
  localparam logic [FUNC_W-1:0] FN_SUBQ   = 7'h29;
  localparam logic [FUNC_W-1:0] FN_SUBQV  = 7'h69;
  localparam logic [FUNC_W-1:0] FN_S4SUBQ = 7'h2b;
  localparam logic [FUNC_W-1:0] FN_S8SUBQ = 7'h3b;
  localparam logic [FUNC_W-1:0] FN_CMPEQ  = 7'h2d;
  localparam logic [FUNC_W-1:0] FN_CMPLE  = 7'h6d;
  localparam logic [FUNC_W-1:0] FN_CMPLT  = 7'h4d;
  localparam logic [FUNC_W-1:0] FN_CMPULE = 7'h3d;
  localparam logic [FUNC_W-1:0] FN_CMPULT = 7'h1d;
  localparam logic [FUNC_W-1:0] FN_BYTEGE = 7'h0f;

  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_ARITH = 2'd1,
    RES_CMP   = 2'd2,
    RES_LANE  = 2'd3
  } resSel_e;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_LES = 3'd1,
    CMP_LTS = 3'd2,
    CMP_LEU = 3'd3,
    CMP_LTU = 3'd4
  } cmpSel_e;

  // Strobes from decode to the datapath.
  typedef struct packed {
    logic    doSub;
    logic    isLong;
    logic [1:0] scaleSh;
    logic    trapEn;
    resSel_e resSel;
    cmpSel_e cmpSel;
    logic    illegal;
  } ctrlStrobes_t;

endpackage

// File: rtl/intArithCtrl.sv
module intArithCtrl
  import intArithPkg::*;
(
  input  logic [FUNC_W-1:0] funcCode,
  output ctrlStrobes_t      ctl
);

  always_comb begin
    ctl = '{doSub: 1'b0, isLong: 1'b0, scaleSh: 2'd0, trapEn: 1'b0,
            resSel: RES_ARITH, cmpSel: CMP_EQ, illegal: 1'b0};
    case (funcCode)
      FN_ADDL:   ctl.isLong = 1'b1;
      FN_ADDLV:  begin ctl.isLong = 1'b1; ctl.trapEn = 1'b1; end
      FN_S4ADDL: begin ctl.isLong = 1'b1; ctl.scaleSh = 2'd2; end
      FN_S8ADDL: begin ctl.isLong = 1'b1; ctl.scaleSh = 2'd3; end
      FN_ADDQ:   ;
      FN_ADDQV:  ctl.trapEn = 1'b1;
      FN_S4ADDQ: ctl.scaleSh = 2'd2;
      FN_S8ADDQ: ctl.scaleSh = 2'd3;
      FN_SUBL:   begin ctl.doSub = 1'b1; ctl.isLong = 1'b1; end
      FN_SUBLV:  begin ctl.doSub = 1'b1; ctl.isLong = 1'b1; ctl.trapEn = 1'b1; end
      FN_S4SUBL: begin ctl.doSub = 1'b1; ctl.isLong = 1'b1; ctl.scaleSh = 2'd2; end
      FN_S8SUBL: begin ctl.doSub = 1'b1; ctl.isLong = 1'b1; ctl.scaleSh = 2'd3; end
      FN_SUBQ:   ctl.doSub = 1'b1;
      FN_SUBQV:  begin ctl.doSub = 1'b1; ctl.trapEn = 1'b1; end
      FN_S4SUBQ: begin ctl.doSub = 1'b1; ctl.scaleSh = 2'd2; end
      FN_S8SUBQ: begin ctl.doSub = 1'b1; ctl.scaleSh = 2'd3; end
      FN_CMPEQ:  begin ctl.doSub = 1'b1; ctl.resSel = RES_CMP; ctl.cmpSel = CMP_EQ;  end
      FN_CMPLE:  begin ctl.doSub = 1'b1; ctl.resSel = RES_CMP; ctl.cmpSel = CMP_LES; end
      FN_CMPLT:  begin ctl.doSub = 1'b1; ctl.resSel = RES_CMP; ctl.cmpSel = CMP_LTS; end
      FN_CMPULE: begin ctl.doSub = 1'b1; ctl.resSel = RES_CMP; ctl.cmpSel = CMP_LEU; end
      FN_CMPULT: begin ctl.doSub = 1'b1; ctl.resSel = RES_CMP; ctl.cmpSel = CMP_LTU; end
      FN_BYTEGE: ctl.resSel = RES_LANE;
      default: begin
        ctl.resSel  = RES_NONE;
        ctl.illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/intArithLaneCmp.sv
module intArithLaneCmp #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] laneA,
  input  logic [DATA_W-1:0] laneB,
  output logic [LANES-1:0]  geMask
);

  for (genvar i = 0; i < LANES; i++) begin : gLane
    assign geMask[i] = laneA[i*LANE_W +: LANE_W] >= laneB[i*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/intArithDatapath.sv
module intArithDatapath
  import intArithPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LONG_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  ctrlStrobes_t      ctl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              overflow
);

  logic [DATA_W-1:0] scaledA;
  logic [DATA_W-1:0] addendB;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] arithRes;
  logic              aSign, bSign, rSign, ovRaw;
  logic              isEq, ltU, ltS, cmpBit;
  logic [LANES-1:0]  laneMask;

  // One shared adder: subtract is A + ~B + 1, compares reuse the carry.
  always_comb begin
    scaledA = opA << ctl.scaleSh;
    addendB = ctl.doSub ? ~opB : opB;
    sumWide = {1'b0, scaledA} + {1'b0, addendB} + {{DATA_W{1'b0}}, ctl.doSub};
  end

  always_comb begin
    if (ctl.isLong) begin
      arithRes = {{(DATA_W-LONG_W){sumWide[LONG_W-1]}}, sumWide[LONG_W-1:0]};
      aSign = scaledA[LONG_W-1];
      bSign = opB[LONG_W-1];
      rSign = sumWide[LONG_W-1];
    end else begin
      arithRes = sumWide[DATA_W-1:0];
      aSign = scaledA[DATA_W-1];
      bSign = opB[DATA_W-1];
      rSign = sumWide[DATA_W-1];
    end
    ovRaw = ctl.doSub ? ((aSign != bSign) && (rSign != aSign))
                      : ((aSign == bSign) && (rSign != aSign));
  end

  always_comb begin
    isEq = (opA == opB);
    ltU  = ~sumWide[DATA_W];
    ltS  = (opA[DATA_W-1] != opB[DATA_W-1]) ? opA[DATA_W-1] : ltU;
    case (ctl.cmpSel)
      CMP_EQ:  cmpBit = isEq;
      CMP_LES: cmpBit = ltS | isEq;
      CMP_LTS: cmpBit = ltS;
      CMP_LEU: cmpBit = ltU | isEq;
      CMP_LTU: cmpBit = ltU;
      default: cmpBit = 1'b0;
    endcase
  end

  intArithLaneCmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) uLaneCmp (
    .laneA (opA),
    .laneB (opB),
    .geMask(laneMask)
  );

  always_comb begin
    case (ctl.resSel)
      RES_ARITH: result = arithRes;
      RES_CMP:   result = {{(DATA_W-1){1'b0}}, cmpBit};
      RES_LANE:  result = {{(DATA_W-LANES){1'b0}}, laneMask};
      default:   result = '0;
    endcase
    overflow = ctl.trapEn && (ctl.resSel == RES_ARITH) && ovRaw;
  end

endmodule

// File: rtl/intArithUnit.sv
module intArithUnit
  import intArithPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LONG_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [FUNC_W-1:0] funcCode,
  output logic [DATA_W-1:0] result,
  output logic              overflow,
  output logic              illegalOp
);

  ctrlStrobes_t ctl;

  intArithCtrl uCtrl (
    .funcCode(funcCode),
    .ctl     (ctl)
  );

  intArithDatapath #(.DATA_W(DATA_W), .LONG_W(LONG_W), .LANE_W(LANE_W)) uPath (
    .ctl     (ctl),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .overflow(overflow)
  );

  assign illegalOp = ctl.illegal;

endmodule

// File: rtl/intArithUnitChk.sv
module intArithUnitChk
  import intArithPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LONG_W = 32,
  parameter int LANE_W = 8
) (
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [FUNC_W-1:0] funcCode,
  input logic [DATA_W-1:0] result,
  input logic              overflow,
  input logic              illegalOp
);

  localparam int LANES = DATA_W / LANE_W;

  logic known, isTrapCode, isScaled, isLongCode, isCmpCode;

  always_comb begin
    known = !$isunknown({opA, opB, funcCode});
    isTrapCode = funcCode inside {FN_ADDLV, FN_ADDQV, FN_SUBLV, FN_SUBQV};
    isScaled   = funcCode inside {FN_S4ADDL, FN_S8ADDL, FN_S4ADDQ, FN_S8ADDQ,
                                  FN_S4SUBL, FN_S8SUBL, FN_S4SUBQ, FN_S8SUBQ};
    isLongCode = funcCode inside {FN_ADDL, FN_ADDLV, FN_S4ADDL, FN_S8ADDL,
                                  FN_SUBL, FN_SUBLV, FN_S4SUBL, FN_S8SUBL};
    isCmpCode  = funcCode inside {FN_CMPEQ, FN_CMPLE, FN_CMPLT, FN_CMPULE, FN_CMPULT};
  end

  always_comb begin
    if (known) begin
      a_r1_long_sext: assert (!isLongCode || result[DATA_W-1:LONG_W] == {(DATA_W-LONG_W){result[LONG_W-1]}})
        else $error("long result not sign-extended");
      a_r3_scaled_no_overflow: assert (!isScaled || !overflow)
        else $error("scaled code raised overflow");
      a_r6_overflow_only_trap: assert (!overflow || isTrapCode)
        else $error("overflow on non-trapping code");
      a_r7_cmp_boolean: assert (!isCmpCode || result[DATA_W-1:1] == '0)
        else $error("compare result not 0/1");
      a_r8_lane_upper_zero: assert (funcCode != FN_BYTEGE || result[DATA_W-1:LANES] == '0)
        else $error("lane compare upper bits set");
      a_r9_illegal_quiet: assert (!illegalOp || (result == '0 && !overflow))
        else $error("illegal code drove outputs");
      a_r9_listed_legal: assert (!(isTrapCode || isScaled || isLongCode || isCmpCode) || !illegalOp)
        else $error("listed code flagged illegal");
    end
  end

endmodule

bind intArithUnit intArithUnitChk #(.DATA_W(DATA_W), .LONG_W(LONG_W), .LANE_W(LANE_W)) uChk (
  .opA(opA), .opB(opB), .funcCode(funcCode),
  .result(result), .overflow(overflow), .illegalOp(illegalOp)
);

// File: tb/intArithUnit_test.sv
`timescale 1ns/1ps
module intArithUnit_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [63:0] opA, opB, result;
  logic [6:0]  funcCode;
  logic        overflow, illegalOp;

  int nVec = 0;
  int nFail = 0;
  bit finished = 1'b0;

  intArithUnit uut (
    .opA(opA), .opB(opB), .funcCode(funcCode),
    .result(result), .overflow(overflow), .illegalOp(illegalOp)
  );

  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic [6:0] validCodes [26] = '{7'h00, 7'h40, 7'h02, 7'h12, 7'h20, 7'h60, 7'h22, 7'h32,
                                  7'h09, 7'h49, 7'h0b, 7'h1b, 7'h29, 7'h69, 7'h2b, 7'h3b,
                                  7'h2d, 7'h6d, 7'h4d, 7'h3d, 7'h1d, 7'h0f,
                                  7'h00, 7'h20, 7'h09, 7'h29};

  // Independent model built from the requirement text.
  task automatic refModel(input logic [63:0] a, input logic [63:0] b, input logic [6:0] f,
                          output logic [63:0] res, output logic ov, output logic ill);
    logic [32:0] w32;
    logic [64:0] w64;
    logic [31:0] a32, b32;
    int sh;
    bit sub, lng, trap;
    res = '0; ov = 1'b0; ill = 1'b0;
    a32 = a[31:0]; b32 = b[31:0];
    sh = 0; sub = 0; lng = 0; trap = 0;
    case (f)
      7'h00: lng = 1;            7'h40: begin lng = 1; trap = 1; end
      7'h02: begin lng = 1; sh = 2; end  7'h12: begin lng = 1; sh = 3; end
      7'h20: ;                   7'h60: trap = 1;
      7'h22: sh = 2;             7'h32: sh = 3;
      7'h09: begin lng = 1; sub = 1; end 7'h49: begin lng = 1; sub = 1; trap = 1; end
      7'h0b: begin lng = 1; sub = 1; sh = 2; end 7'h1b: begin lng = 1; sub = 1; sh = 3; end
      7'h29: sub = 1;            7'h69: begin sub = 1; trap = 1; end
      7'h2b: begin sub = 1; sh = 2; end 7'h3b: begin sub = 1; sh = 3; end
      default: ;
    endcase
    case (f)
      7'h2d: res = {63'd0, a == b};
      7'h6d: res = {63'd0, $signed(a) <= $signed(b)};
      7'h4d: res = {63'd0, $signed(a) <  $signed(b)};
      7'h3d: res = {63'd0, a <= b};
      7'h1d: res = {63'd0, a <  b};
      7'h0f: for (int i = 0; i < 8; i++) res[i] = (a[8*i +: 8] >= b[8*i +: 8]);
      7'h00, 7'h40, 7'h02, 7'h12, 7'h20, 7'h60, 7'h22, 7'h32,
      7'h09, 7'h49, 7'h0b, 7'h1b, 7'h29, 7'h69, 7'h2b, 7'h3b: begin
        if (lng) begin
          w32 = sub ? ({a32[31], a32 << sh} - {b32[31], b32}) : ({a32[31], a32 << sh} + {b32[31], b32});
          res = {{32{w32[31]}}, w32[31:0]};
          ov  = trap && (w32[32] != w32[31]);
        end else begin
          w64 = sub ? ({a[63], a << sh} - {b[63], b}) : ({a[63], a << sh} + {b[63], b});
          res = w64[63:0];
          ov  = trap && (w64[64] != w64[63]);
        end
      end
      default: ill = 1'b1;
    endcase
  endtask

  task automatic check(input string req, input logic [63:0] a, input logic [63:0] b,
                       input logic [6:0] f);
    logic [63:0] eRes;
    logic eOv, eIll;
    @(negedge clk);
    opA = a; opB = b; funcCode = f;
    #1;
    refModel(a, b, f, eRes, eOv, eIll);
    nVec++;
    if (result !== eRes || overflow !== eOv || illegalOp !== eIll) begin
      nFail++;
      $display("FAIL %s code=%h a=%h b=%h: got res=%h ov=%b ill=%b, expected res=%h ov=%b ill=%b",
               req, f, a, b, result, overflow, illegalOp, eRes, eOv, eIll);
    end
  endtask

  function automatic string reqOf(input logic [6:0] f);
    case (f)
      7'h00, 7'h09: return "R1";
      7'h20, 7'h29: return "R2";
      7'h40, 7'h60: return "R4";
      7'h49, 7'h69: return "R5";
      7'h2d, 7'h6d, 7'h4d, 7'h3d, 7'h1d: return "R7";
      7'h0f: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic testReset();
    check("R1", 64'd0, 64'd0, 7'h00);  // quiet state after reset
  endtask

  task automatic testLong();           // R1
    check("R1", 64'hFFFF_FFFF_7FFF_FFFF, 64'h1234_0000_0000_0001, 7'h00);
    check("R1", 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 7'h09);
    check("R1", 64'hAAAA_AAAA_0000_0005, 64'h5555_5555_0000_0003, 7'h09);
  endtask

  task automatic testQuad();           // R2
    check("R2", ONES, 64'd1, 7'h20);
    check("R2", 64'd0, 64'd1, 7'h29);
    check("R2", 64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, 7'h20);
  endtask

  task automatic testScaled();         // R3
    foreach (validCodes[k]) begin
      if (reqOf(validCodes[k]) == "R3") begin
        check("R3", MAXP, 64'd1, validCodes[k]);
        check("R3", MINN, MAXP, validCodes[k]);
        check("R3", 64'h0000_0000_4000_0001, ONES, validCodes[k]);
      end
    end
  endtask

  task automatic testAddTrap();        // R4
    check("R4", MAXP, 64'd1, 7'h60);
    check("R4", MINN, ONES, 7'h60);
    check("R4", MAXP, MINN, 7'h60);
    check("R4", 64'h0000_0000_7FFF_FFFF, 64'd1, 7'h40);
    check("R4", 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 7'h40);
    check("R4", 64'd5, 64'd6, 7'h40);
  endtask

  task automatic testSubTrap();        // R5
    check("R5", MINN, 64'd1, 7'h69);
    check("R5", MAXP, ONES, 7'h69);
    check("R5", ONES, ONES, 7'h69);
    check("R5", 64'h0000_0000_8000_0000, 64'd1, 7'h49);
    check("R5", 64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 7'h49);
  endtask

  task automatic testNoTrap();         // R6
    check("R6", MAXP, 64'd1, 7'h20);
    check("R6", 64'h0000_0000_7FFF_FFFF, 64'd1, 7'h00);
    check("R6", MINN, 64'd1, 7'h29);
    check("R6", MAXP, ONES, 7'h2d);
  endtask

  task automatic testCompare();        // R7
    logic [63:0] vals [4] = '{MAXP, MINN, ONES, 64'd0};
    foreach (vals[i]) foreach (vals[j]) begin
      check("R7", vals[i], vals[j], 7'h2d);
      check("R7", vals[i], vals[j], 7'h6d);
      check("R7", vals[i], vals[j], 7'h4d);
      check("R7", vals[i], vals[j], 7'h3d);
      check("R7", vals[i], vals[j], 7'h1d);
    end
  endtask

  task automatic testLanes();          // R8
    check("R8", 64'h00FF_7F80_0102_FE01, 64'h0100_7F7F_0201_FF01, 7'h0f);
    check("R8", ONES, ONES, 7'h0f);
    check("R8", 64'd0, ONES, 7'h0f);
  endtask

  task automatic testIllegal();        // R9
    check("R9", MAXP, 64'd1, 7'h01);
    check("R9", ONES, ONES, 7'h7f);
    check("R9", MINN, 64'd3, 7'h10);
    check("R9", 64'd9, 64'd2, 7'h0e);
  endtask

  task automatic testRandom();
    for (int n = 0; n < 40; n++) begin
      foreach (validCodes[k]) begin
        check(reqOf(validCodes[k]), {$urandom, $urandom}, {$urandom, $urandom}, validCodes[k]);
      end
    end
  endtask

  initial begin
    opA = '0; opB = '0; funcCode = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testReset();
    testLong();
    testQuad();
    testScaled();
    testAddTrap();
    testSubTrap();
    testNoTrap();
    testCompare();
    testLanes();
    testIllegal();
    testRandom();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nFail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

endmodule